// File: doc/BRIEF.md
# Protection Lookaside Lookup Unit

This block checks every data access against a small table of installed page descriptors. The table has sixteen entries. Each entry holds a page start address and a 32-bit descriptor word. The descriptor gives the page a valid bit, a size code and permission and cache-policy bits. For each access, the block reports in the same cycle one of four outcomes: a single clean hit, a miss, a multiple hit or a protection violation. Each fault outcome comes with a six-bit cause code.

When an access faults, the block latches two values for a controller or exception handler to read. The first is the faulting address. The second is a status word holding the one-hot mask of the matching entries, the write flag and the supervisor flag. A simple register port lets a controller read and write the entries, switch checking on and off, and read back the captured fault state. The block installs nothing by itself: refill, eviction and dirty marking are left to whatever reads the captured state.

Top module: `prot_lookaside`

## Requirements
- R1: After reset, every descriptor and start register reads zero, so no entry is valid. The control register reads zero, meaning checking is off. The fault address and fault status registers read zero.
- R2: The register port decodes `reg_addr_i` as follows:
  - With bit 5 clear, bit 4 selects the start register (0) or the descriptor (1) of the entry indexed by bits 3:0.
  - Address 0x20 is the control register, with bit 0 enabling checking.
  - Address 0x21 reads the fault address and address 0x22 reads the fault status; both are read-only.
  - A written value reads back unchanged.
- R3: An entry matches an address only if all of these hold:
  - descriptor bit 0 (valid) is set;
  - start <= address, compared unsigned;
  - address < start + size, compared unsigned over 33 bits.

  The size comes from descriptor bits 17:16: 00 is 1 KB, 01 is 4 KB, 10 is 1 MB and 11 is 4 MB.
- R4: With checking on, an access that matches exactly one entry and breaks no rule raises `acc_hit_o` and `acc_ok_o`, with cause 0.
- R5: With checking on, an access that matches no entry raises `acc_miss_o` with cause 0x26.
- R6: With checking on, an access that matches two or more entries raises `acc_multi_o` with cause 0x27. This outcome wins over any protection result.
- R7: A write whose single matching entry lacks write permission for the access mode raises `acc_prot_o` with cause 0x23. Descriptor bit 3 grants user writes and bit 4 grants supervisor writes.
- R8: A write to a single matching page that is write-back (bit 14 = 0) and clean (bit 7 = 0) raises `acc_prot_o` with cause 0x23, even when the page grants permission. Reads never raise a protection fault.
- R9: On a valid faulting access, the next clock edge captures the access address into the fault address register. The same edge captures the fault status as {14'b0, supervisor, write, 16-bit match mask}.
- R10: An access that does not fault, or a cycle with `acc_valid_i` low, leaves the fault address and fault status unchanged. With `acc_valid_i` low, all result flags are 0.
- R11: With checking off, every valid access reports `acc_ok_o` = 1 and all fault flags 0, and no fault state is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_addr_i | input | 32 | Access address |
| acc_write_i | input | 1 | Access is a write |
| acc_super_i | input | 1 | Access is in supervisor mode |
| acc_ok_o | output | 1 | Access may proceed |
| acc_hit_o | output | 1 | Single clean match |
| acc_miss_o | output | 1 | No entry matched |
| acc_prot_o | output | 1 | Protection violation |
| acc_multi_o | output | 1 | More than one entry matched |
| fault_cause_o | output | 6 | Cause of the current fault, 0 if none |

## Verification
A corrupted descriptor or start register shows up as a wrong outcome flag on the very first access that touches that page. It also shows up at once on a register read of that entry. An off-by-one in the page end comparison appears only at the last byte of a page or the first byte after it, so the stimulus hits both sides of every size code. A fault-capture fault is visible one edge after the faulting access, through reads of the address and status registers. These reads follow every access, so a stale or spurious capture is caught before the next access.

// File: rtl/prot_lookaside_pkg.sv
package prot_lookaside_pkg;
  localparam int unsigned DESC_W    = 32;
  localparam int unsigned REG_AW    = 6;
  localparam int unsigned STAT_MASK = 16;

  localparam int unsigned B_VALID   = 0;
  localparam int unsigned B_USR_WR  = 3;
  localparam int unsigned B_SUP_WR  = 4;
  localparam int unsigned B_DIRTY   = 7;
  localparam int unsigned B_WTHRU   = 14;
  localparam int unsigned B_SIZE_LO = 16;

  localparam logic [5:0] CAUSE_NONE  = 6'h00;
  localparam logic [5:0] CAUSE_PROT  = 6'h23;
  localparam logic [5:0] CAUSE_MISS  = 6'h26;
  localparam logic [5:0] CAUSE_MULTI = 6'h27;

  localparam logic [REG_AW-1:0] A_CTRL  = 6'h20;
  localparam logic [REG_AW-1:0] A_FADDR = 6'h21;
  localparam logic [REG_AW-1:0] A_FSTAT = 6'h22;

  typedef struct packed {
    logic wthru;
    logic dirty;
    logic sup_wr;
    logic usr_wr;
  } page_attr_t;
endpackage

// File: rtl/prot_lookaside_match.sv
module prot_lookaside_match #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              valid_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W:0] ONE = (ADDR_W+1)'(1);

  logic [ADDR_W:0] span, page_end;

  always_comb begin
    unique case (size_i)
      2'b00:   span = ONE << 10;
      2'b01:   span = ONE << 12;
      2'b10:   span = ONE << 20;
      default: span = ONE << 22;
    endcase
    page_end = {1'b0, start_i} + span;
    hit_o = valid_i && (addr_i >= start_i) && ({1'b0, addr_i} < page_end);
  end
endmodule

// File: rtl/prot_lookaside_judge.sv
module prot_lookaside_judge
  import prot_lookaside_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16
) (
  input  logic                   active_i,
  input  logic                   write_i,
  input  logic                   super_i,
  input  logic [NUM_ENTRIES-1:0] match_i,
  input  page_attr_t             attr_i [NUM_ENTRIES],
  output logic                   hit_o,
  output logic                   miss_o,
  output logic                   prot_o,
  output logic                   multi_o,
  output logic [5:0]             cause_o
);
  page_attr_t sel;
  logic any, many, perm, bad;

  always_comb begin
    sel = '0;
    for (int i = 0; i < int'(NUM_ENTRIES); i++)
      if (match_i[i]) sel = sel | attr_i[i];
    any  = |match_i;
    many = |(match_i & (match_i - 1'b1));
    perm = super_i ? sel.sup_wr : sel.usr_wr;
    // clean write-back pages fault on first write
    bad  = write_i && (!perm || (!sel.wthru && !sel.dirty));

    miss_o  = active_i && !any;
    multi_o = active_i && many;
    prot_o  = active_i && any && !many && bad;
    hit_o   = active_i && any && !many && !bad;

    if (multi_o)     cause_o = CAUSE_MULTI;
    else if (miss_o) cause_o = CAUSE_MISS;
    else if (prot_o) cause_o = CAUSE_PROT;
    else             cause_o = CAUSE_NONE;
  end
endmodule

// File: rtl/prot_lookaside.sv
module prot_lookaside
  import prot_lookaside_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned ADDR_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [5:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_write_i,
  input  logic              acc_super_i,
  output logic              acc_ok_o,
  output logic              acc_hit_o,
  output logic              acc_miss_o,
  output logic              acc_prot_o,
  output logic              acc_multi_o,
  output logic [5:0]        fault_cause_o
);
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES);

  logic [ADDR_W-1:0]      start_q [NUM_ENTRIES];
  logic [DESC_W-1:0]      desc_q  [NUM_ENTRIES];
  logic                   en_q;
  logic [ADDR_W-1:0]      fault_addr_q;
  logic [31:0]            fault_stat_q;
  logic [NUM_ENTRIES-1:0] match_vec;
  page_attr_t             attr    [NUM_ENTRIES];
  logic                   fault;
  logic [STAT_MASK-1:0]   mask_ext;
  logic [IDX_W-1:0]       ridx;

  assign ridx = reg_addr_i[IDX_W-1:0];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    assign attr[g] = '{wthru:  desc_q[g][B_WTHRU],
                       dirty:  desc_q[g][B_DIRTY],
                       sup_wr: desc_q[g][B_SUP_WR],
                       usr_wr: desc_q[g][B_USR_WR]};
    prot_lookaside_match #(.ADDR_W(ADDR_W)) u_match (
      .valid_i (desc_q[g][B_VALID]),
      .size_i  (desc_q[g][B_SIZE_LO +: 2]),
      .start_i (start_q[g]),
      .addr_i  (acc_addr_i),
      .hit_o   (match_vec[g])
    );
  end

  prot_lookaside_judge #(.NUM_ENTRIES(NUM_ENTRIES)) u_judge (
    .active_i (acc_valid_i && en_q),
    .write_i  (acc_write_i),
    .super_i  (acc_super_i),
    .match_i  (match_vec),
    .attr_i   (attr),
    .hit_o    (acc_hit_o),
    .miss_o   (acc_miss_o),
    .prot_o   (acc_prot_o),
    .multi_o  (acc_multi_o),
    .cause_o  (fault_cause_o)
  );

  assign fault    = acc_miss_o || acc_prot_o || acc_multi_o;
  assign acc_ok_o = acc_valid_i && !fault;

  always_comb begin
    mask_ext = '0;
    mask_ext[NUM_ENTRIES-1:0] = match_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NUM_ENTRIES); i++) begin
        start_q[i] <= '0;
        desc_q[i]  <= '0;
      end
      en_q         <= 1'b0;
      fault_addr_q <= '0;
      fault_stat_q <= '0;
    end else begin
      if (reg_we_i) begin
        if (!reg_addr_i[5]) begin
          if (reg_addr_i[4]) desc_q[ridx]  <= reg_wdata_i;
          else               start_q[ridx] <= reg_wdata_i[ADDR_W-1:0];
        end else if (reg_addr_i == A_CTRL) begin
          en_q <= reg_wdata_i[0];
        end
      end
      if (acc_valid_i && fault) begin
        fault_addr_q <= acc_addr_i;
        fault_stat_q <= {14'b0, acc_super_i, acc_write_i, mask_ext};
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (!reg_addr_i[5]) begin
      if (reg_addr_i[4]) reg_rdata_o = desc_q[ridx];
      else               reg_rdata_o = 32'(start_q[ridx]);
    end else begin
      unique case (reg_addr_i)
        A_CTRL:  reg_rdata_o = {31'b0, en_q};
        A_FADDR: reg_rdata_o = 32'(fault_addr_q);
        A_FSTAT: reg_rdata_o = fault_stat_q;
        default: reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/prot_lookaside_checker.sv
module prot_lookaside_checker #(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned ADDR_W      = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   acc_valid_i,
  input logic [ADDR_W-1:0]      acc_addr_i,
  input logic                   en_q,
  input logic [NUM_ENTRIES-1:0] match_vec,
  input logic                   acc_hit_o,
  input logic                   acc_miss_o,
  input logic                   acc_prot_o,
  input logic                   acc_multi_o,
  input logic [5:0]             fault_cause_o,
  input logic [ADDR_W-1:0]      fault_addr_q,
  input logic [31:0]            fault_stat_q
);
  logic flt;
  assign flt = acc_miss_o || acc_prot_o || acc_multi_o;

  assert_hit_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_hit_o |-> ($countones(match_vec) == 1 && fault_cause_o == 6'h00));
  assert_miss_none_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_miss_o |-> (match_vec == '0 && fault_cause_o == 6'h26));
  assert_multi_many_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_multi_o |-> ($countones(match_vec) > 1 && fault_cause_o == 6'h27));
  assert_prot_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_prot_o |-> ($countones(match_vec) == 1 && fault_cause_o == 6'h23));
  assert_capture_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && flt) |=> fault_addr_q == $past(acc_addr_i));
  assert_hold_fault_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_valid_i && flt) |=> ($stable(fault_addr_q) && $stable(fault_stat_q)));
  assert_off_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !(flt || acc_hit_o));
endmodule

bind prot_lookaside prot_lookaside_checker #(
  .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .acc_valid_i(acc_valid_i), .acc_addr_i(acc_addr_i),
  .en_q(en_q), .match_vec(match_vec), .acc_hit_o(acc_hit_o), .acc_miss_o(acc_miss_o),
  .acc_prot_o(acc_prot_o), .acc_multi_o(acc_multi_o), .fault_cause_o(fault_cause_o),
  .fault_addr_q(fault_addr_q), .fault_stat_q(fault_stat_q)
);

// File: tb/prot_lookaside_bench.sv
module prot_lookaside_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        acc_super = 1'b0;
  logic        ok, hit, miss, prot, multi;
  logic [5:0]  cause;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] m_faddr = '0;
  logic [31:0] m_fstat = '0;

  always #4 clk = ~clk;

  prot_lookaside u_prot_lookaside (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .acc_valid_i(acc_valid),
    .acc_addr_i(acc_addr), .acc_write_i(acc_write), .acc_super_i(acc_super),
    .acc_ok_o(ok), .acc_hit_o(hit), .acc_miss_o(miss), .acc_prot_o(prot),
    .acc_multi_o(multi), .fault_cause_o(cause)
  );

  // exp = {hit, miss, prot, multi}
  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic        sup;
    logic [3:0]  exp;
    logic [15:0] mask;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{32'h0000_1000, 1'b0, 1'b0, 4'b1000, 16'h0001},  // R3 first byte, 4 KB
    '{32'h0000_1FFF, 1'b1, 1'b0, 4'b1000, 16'h0001},  // R3 last byte
    '{32'h0000_2000, 1'b0, 1'b0, 4'b0100, 16'h0000},  // R3 one past end
    '{32'h0000_0FFF, 1'b0, 1'b0, 4'b0100, 16'h0000},
    '{32'h0000_07FF, 1'b1, 1'b0, 4'b1000, 16'h0008},  // R3 1 KB last byte
    '{32'h0000_07FF, 1'b1, 1'b1, 4'b0010, 16'h0008},  // no super write
    '{32'h0000_0800, 1'b0, 1'b0, 4'b0100, 16'h0000},
    '{32'h0000_1800, 1'b0, 1'b0, 4'b0001, 16'h0011},
    '{32'h0000_1800, 1'b1, 1'b0, 4'b0001, 16'h0011},  // multi beats prot check
    '{32'h0010_0000, 1'b0, 1'b0, 4'b1000, 16'h0002},  // WB clean read ok
    '{32'h001F_FFFF, 1'b1, 1'b1, 4'b0010, 16'h0002},  // WB clean write
    '{32'h0020_0000, 1'b0, 1'b0, 4'b0100, 16'h0000},  // R3 1 MB end
    '{32'h0040_0000, 1'b1, 1'b1, 4'b1000, 16'h0004},  // dirty, super write
    '{32'h007F_FFFF, 1'b1, 1'b0, 4'b0010, 16'h0004},  // no user write
    '{32'h0080_0000, 1'b0, 1'b0, 4'b0100, 16'h0000},  // R3 invalid entry
    '{32'h003F_FFFF, 1'b0, 1'b0, 4'b0100, 16'h0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read_check(input string tag, input logic [5:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic fault_regs_check(input string tag);
    reg_read_check(tag, 6'h21, m_faddr);
    reg_read_check(tag, 6'h22, m_fstat);
  endtask

  function automatic string tag_of(input logic [3:0] e);
    if (e[3]) return "R4";
    if (e[2]) return "R5";
    if (e[0]) return "R6";
    return "R7|R8";
  endfunction

  function automatic logic [5:0] cause_of(input logic [3:0] e);
    if (e[0]) return 6'h27;
    if (e[2]) return 6'h26;
    if (e[1]) return 6'h23;
    return 6'h00;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    reg_read_check("R1 desc0", 6'h10, 32'h0);
    reg_read_check("R1 desc15", 6'h1F, 32'h0);
    reg_read_check("R1 start7", 6'h07, 32'h0);
    reg_read_check("R1 ctrl", 6'h20, 32'h0);
    fault_regs_check("R1 fault");

    // R11 checking off: anything passes, nothing captured
    acc_valid = 1'b1; acc_addr = 32'h0000_5000; acc_write = 1'b1;
    #1;
    check("R11 flags", {26'b0, ok, hit, miss, prot, multi, 1'b0}, {26'b0, 1'b1, 5'b0});
    @(negedge clk);
    acc_valid = 1'b0;
    fault_regs_check("R11 no capture");

    // R2 programming and readback
    reg_write(6'h00, 32'h0000_1000); reg_write(6'h10, 32'h0001_4019);
    reg_write(6'h01, 32'h0010_0000); reg_write(6'h11, 32'h0002_0019);
    reg_write(6'h02, 32'h0040_0000); reg_write(6'h12, 32'h0003_0091);
    reg_write(6'h03, 32'h0000_0400); reg_write(6'h13, 32'h0000_4009);
    reg_write(6'h04, 32'h0000_1800); reg_write(6'h14, 32'h0000_4019);
    reg_write(6'h05, 32'h0080_0000); reg_write(6'h15, 32'h0001_4018);
    reg_read_check("R2 start2", 6'h02, 32'h0040_0000);
    reg_read_check("R2 desc2", 6'h12, 32'h0003_0091);
    reg_write(6'h21, 32'hDEAD_BEEF);
    reg_read_check("R2 faddr ro", 6'h21, 32'h0);
    reg_write(6'h20, 32'h1);
    reg_read_check("R2 ctrl", 6'h20, 32'h1);

    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = VEC[i].addr;
      acc_write = VEC[i].wr; acc_super = VEC[i].sup;
      #1;
      check(tag_of(VEC[i].exp), {28'b0, hit, miss, prot, multi}, {28'b0, VEC[i].exp});
      check(tag_of(VEC[i].exp), {26'b0, cause}, {26'b0, cause_of(VEC[i].exp)});
      check(tag_of(VEC[i].exp), {31'b0, ok}, {31'b0, VEC[i].exp[3]});
      @(negedge clk);
      acc_valid = 1'b0;
      if (!VEC[i].exp[3]) begin
        m_faddr = VEC[i].addr;
        m_fstat = {14'b0, VEC[i].sup, VEC[i].wr, VEC[i].mask};
      end
      fault_regs_check(VEC[i].exp[3] ? "R10 hold" : "R9 capture");
    end

    // R10 idle cycle with a missing address
    acc_addr = 32'h0900_0000;
    #1;
    check("R10 idle flags", {27'b0, ok, hit, miss, prot, multi}, 32'h0);
    @(negedge clk);
    fault_regs_check("R10 idle");

    // R11 disable again, then a would-be miss
    reg_write(6'h20, 32'h0);
    acc_valid = 1'b1; acc_write = 1'b0;
    #1;
    check("R11 off miss", {27'b0, ok, hit, miss, prot, multi}, {27'b0, 5'b10000});
    @(negedge clk);
    acc_valid = 1'b0;
    fault_regs_check("R11 off hold");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule